// File: doc/BRIEF.md
# Parallel BCD Add/Subtract Unit

This block adds or subtracts two packed decimal operands of `NUM_DIGITS` digits each, with no clock. Every digit slice first passes its A digit through a gated nines complementer. It then adds the result to the matching B digit in a decimal-corrected adder. The carry ripples from the units digit toward the most significant digit.

Subtraction works by tens complement. The complementer inverts A, and the units carry-in is set to one. The block flags a negative result, which it presents in tens-complement form.

Three controls steer the complementer stage:
- A complement-disable input blocks the subtract request.
- A zero-force input drives the complementer output to zero, so the result is B unchanged.
- Non-decimal input codes on A map to fixed values when complemented.

Top module: `bcd_addsub`

## Requirements
- R1: Digits use the 8-4-2-1 weighted code. Digit i occupies bits [4i+3:4i] of each operand and of the result, with digit 0 as the units. With `sub_i`=0 and `zero_i`=0, `sum_o` is (B+A) mod 10^N and `carry_o` is 1 exactly when B+A ≥ 10^N.
- R2: With `sub_i`=1, `comp_dis_i`=0 and `zero_i`=0, `sum_o` is (B−A) mod 10^N and `carry_o` is 1 exactly when B ≥ A.
- R3: `neg_o` is 1 exactly when `sub_i`=1, `comp_dis_i`=0, `zero_i`=0 and B < A. In every other case it is 0.
- R4: With `zero_i`=1, `sum_o` equals B and `carry_o`=`neg_o`=0, whatever A, `sub_i` and `comp_dis_i` are.
- R5: With `comp_dis_i`=1 and `zero_i`=0, A passes uncomplemented and the units carry-in is 0. The result is therefore B+A as in R1, even when `sub_i`=1.
- R6: When complementing, an A digit d in 0..9 becomes 9−d. The codes 10 through 15 become 7, 6, 5, 4, 3 and 2 respectively. For example, with B=0 and complementing active, an A units digit of 10 yields a units result of 7+1=8.
- R7: A carry out of each digit enters the next more significant digit. For example, 99+01 at two digits gives `sum_o`=00 with `carry_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4*NUM_DIGITS | Operand A, packed BCD, goes through the complementer |
| b_i | input | 4*NUM_DIGITS | Operand B, packed BCD |
| sub_i | input | 1 | 1 selects B minus A |
| comp_dis_i | input | 1 | 1 blocks complementing of A |
| zero_i | input | 1 | 1 forces the complementer output to zero |
| sum_o | output | 4*NUM_DIGITS | Packed BCD result |
| carry_o | output | 1 | Decimal carry out of the top digit |
| neg_o | output | 1 | Subtraction result is negative (tens-complement form) |

## Verification
The bench compares every legal pair of two-digit operands in both add and subtract modes against integer arithmetic. This catches a missing +6 correction, a lost carry between digits, or a units carry-in that does not follow the mode; each of these corrupts sums near 9, 99 and B=A.

Directed cases cover the following:
- Subtraction that lands exactly on zero and one below zero. An inverted borrow sense would flip `carry_o` and `neg_o` there.
- Non-decimal A codes under complementing. A plain 9−d would show results above 9 or wrap incorrectly.
- Zero-force while subtracting. A design that leaves the carry-in at one would return B+1 instead of B.
- Random vectors with the disable input set. These expose a design that still complements A or still injects the carry.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned DEC_MAX = 9;
  typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/bcd_nines_gate.sv
module bcd_nines_gate
  import bcd_pkg::*;
(
  input  digit_t d_i,
  input  logic   inv_i,
  input  logic   zero_i,
  output digit_t d_o
);
  digit_t nines;

  // fixed equations: also give 10..15 -> 7..2
  always_comb begin
    nines[0] = ~d_i[0];
    nines[1] =  d_i[1];
    nines[2] =  d_i[1] ^ d_i[2];
    nines[3] = ~(d_i[1] | d_i[2] | d_i[3]);
  end

  always_comb begin
    if (zero_i)     d_o = '0;
    else if (inv_i) d_o = nines;
    else            d_o = d_i;
  end
endmodule

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder
  import bcd_pkg::*;
(
  input  digit_t x_i,
  input  digit_t y_i,
  input  logic   c_i,
  output digit_t s_o,
  output logic   c_o
);
  logic [DIGIT_W:0] raw;
  logic [DIGIT_W:0] fixed;

  always_comb begin
    raw   = {1'b0, x_i} + {1'b0, y_i} + {{DIGIT_W{1'b0}}, c_i};
    c_o   = (raw > (DIGIT_W+1)'(DEC_MAX));
    fixed = c_o ? raw + (DIGIT_W+1)'(6) : raw;
    s_o   = fixed[DIGIT_W-1:0];
  end
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcd_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4,
  localparam int unsigned VEC_W = NUM_DIGITS * DIGIT_W
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic             sub_i,
  input  logic             comp_dis_i,
  input  logic             zero_i,
  output logic [VEC_W-1:0] sum_o,
  output logic             carry_o,
  output logic             neg_o
);
  logic             inv_en;
  logic [NUM_DIGITS:0] carry;

  assign inv_en   = sub_i & ~comp_dis_i;
  // tens complement: +1 at the units digit only when really complementing
  assign carry[0] = inv_en & ~zero_i;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_slice
    digit_t a_d, b_d, f_d, s_d;
    assign a_d = a_i[g*DIGIT_W +: DIGIT_W];
    assign b_d = b_i[g*DIGIT_W +: DIGIT_W];

    bcd_nines_gate u_gate (
      .d_i    (a_d),
      .inv_i  (inv_en),
      .zero_i (zero_i),
      .d_o    (f_d)
    );

    bcd_digit_adder u_add (
      .x_i (f_d),
      .y_i (b_d),
      .c_i (carry[g]),
      .s_o (s_d),
      .c_o (carry[g+1])
    );

    assign sum_o[g*DIGIT_W +: DIGIT_W] = s_d;
  end

  assign carry_o = carry[NUM_DIGITS];
  assign neg_o   = inv_en & ~zero_i & ~carry[NUM_DIGITS];
endmodule

// File: rtl/bcd_addsub_chk.sv
module bcd_addsub_chk
  import bcd_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4,
  localparam int unsigned VEC_W = NUM_DIGITS * DIGIT_W
) (
  input logic [VEC_W-1:0] a_i,
  input logic [VEC_W-1:0] b_i,
  input logic             sub_i,
  input logic             comp_dis_i,
  input logic             zero_i,
  input logic [VEC_W-1:0] sum_o,
  input logic             carry_o,
  input logic             neg_o
);
  function automatic logic all_dec(input logic [VEC_W-1:0] v);
    logic ok = 1'b1;
    for (int i = 0; i < NUM_DIGITS; i++)
      if (v[i*DIGIT_W +: DIGIT_W] > digit_t'(DEC_MAX)) ok = 1'b0;
    return ok;
  endfunction

  always_comb begin
    // R4
    zero_returns_b_chk: assert (!zero_i || (sum_o == b_i && !carry_o && !neg_o));
    // R3
    neg_needs_sub_chk: assert (!neg_o || (sub_i && !comp_dis_i && !zero_i));
    // R3
    neg_excl_carry_chk: assert (!(neg_o && carry_o));
    // R1
    dec_result_chk: assert (!(all_dec(a_i) && all_dec(b_i)) || all_dec(sum_o));
    // R5
    add_zero_a_chk: assert (!(a_i == '0 && !zero_i && (comp_dis_i || !sub_i) && all_dec(b_i))
                            || (sum_o == b_i && !carry_o));
  end
endmodule

bind bcd_addsub bcd_addsub_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .a_i(a_i), .b_i(b_i), .sub_i(sub_i), .comp_dis_i(comp_dis_i), .zero_i(zero_i),
  .sum_o(sum_o), .carry_o(carry_o), .neg_o(neg_o)
);

// File: tb/bcd_addsub_test.sv
module bcd_addsub_test;
  localparam int N = 2;
  localparam int W = 4 * N;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] a, b, sum;
  logic sub, dis, zero, carry, neg;
  int tests = 0, fails = 0, cycles = 0;

  bcd_addsub #(.NUM_DIGITS(N)) uut (
    .a_i(a), .b_i(b), .sub_i(sub), .comp_dis_i(dis), .zero_i(zero),
    .sum_o(sum), .carry_o(carry), .neg_o(neg)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000) begin
      fails++;
      $display("FAIL watchdog: expired after %0d cycles (expected completion)", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [W-1:0] to_bcd(input int v);
    logic [W-1:0] r;
    for (int i = 0; i < N; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic int nine_of(input int d);
    return (d <= 9) ? 9 - d : 17 - d;
  endfunction

  // digit-serial reference: returns {neg, carry, sum}
  function automatic logic [W+1:0] model(input logic [W-1:0] av, input logic [W-1:0] bv,
                                         input logic s, input logic d, input logic z);
    logic act = s & ~d;
    int c = (act && !z) ? 1 : 0;
    logic [W-1:0] r;
    for (int i = 0; i < N; i++) begin
      int ad = int'(av[4*i +: 4]);
      int f = z ? 0 : (act ? nine_of(ad) : ad);
      int t = f + int'(bv[4*i +: 4]) + c;
      c = (t > 9) ? 1 : 0;
      if (t > 9) t -= 10;
      r[4*i +: 4] = 4'(t);
    end
    return {act & ~z & (c == 0), c[0], r};
  endfunction

  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic s, input logic d, input logic z,
                       input logic [W-1:0] es, input logic ec, input logic en,
                       input string req);
    @(negedge clk);
    a = av; b = bv; sub = s; dis = d; zero = z;
    @(posedge clk); #1;
    tests++;
    if (sum !== es || carry !== ec || neg !== en) begin
      fails++;
      $display("FAIL %s: a=%h b=%h sub=%b dis=%b zero=%b got sum=%h c=%b n=%b exp sum=%h c=%b n=%b",
               req, av, bv, s, d, z, sum, carry, neg, es, ec, en);
    end
  endtask

  task automatic apply_model(input logic [W-1:0] av, input logic [W-1:0] bv,
                             input logic s, input logic d, input logic z, input string req);
    logic [W+1:0] m = model(av, bv, s, d, z);
    apply(av, bv, s, d, z, m[W-1:0], m[W], m[W+1], req);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    a = '0; b = '0; sub = 1'b0; dis = 1'b0; zero = 1'b0;
    // reset-state style check: all-zero inputs give zero result (R1)
    apply('0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R1 idle");

    // R7 ripple corner cases
    apply(8'h01, 8'h99, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R7 99+1");
    apply(8'h01, 8'h09, 1'b0, 1'b0, 1'b0, 8'h10, 1'b0, 1'b0, "R7 9+1");
    // R2/R3 boundaries
    apply(8'h42, 8'h42, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R2 equal");
    apply(8'h43, 8'h42, 1'b1, 1'b0, 1'b0, 8'h99, 1'b0, 1'b1, "R3 minus one");
    // R4 zero while subtracting
    apply(8'h37, 8'h58, 1'b1, 1'b0, 1'b1, 8'h58, 1'b0, 1'b0, "R4 zero sub");
    // R6 illegal codes: units 10..15 -> 7..2, result +1 from carry-in, tens 0 -> 9
    for (int k = 10; k <= 15; k++)
      apply(8'(k), 8'h00, 1'b1, 1'b0, 1'b0, to_bcd(90 + (17 - k) + 1), 1'b0, 1'b1, "R6 illegal");
    // R5 disable with subtract
    apply(8'h25, 8'h17, 1'b1, 1'b1, 1'b0, 8'h42, 1'b0, 1'b0, "R5 dis");

    // R1/R2/R3 exhaustive against integer arithmetic
    for (int ai = 0; ai < 100; ai++)
      for (int bi = 0; bi < 100; bi++) begin
        apply(to_bcd(ai), to_bcd(bi), 1'b0, 1'b0, 1'b0,
              to_bcd((ai + bi) % 100), (ai + bi) >= 100, 1'b0, "R1 add");
        apply(to_bcd(ai), to_bcd(bi), 1'b1, 1'b0, 1'b0,
              to_bcd((bi - ai + 100) % 100), bi >= ai, bi < ai, "R2/R3 sub");
      end

    // random: zero-force (R4), disable (R5), illegal A under complement (R6)
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra = to_bcd(int'($urandom % 100));
      logic [W-1:0] rb = to_bcd(int'($urandom % 100));
      logic rs = 1'($urandom);
      apply(8'($urandom), rb, rs, 1'($urandom), 1'b1, rb, 1'b0, 1'b0, "R4 random zero");
      apply_model(ra, rb, rs, 1'b1, 1'b0, "R5 random dis");
      apply_model(8'($urandom), rb, 1'b1, 1'b0, 1'b0, "R6 random illegal");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule